// File: doc/BRIEF.md
# Snapshot-Coherent SPI Register Port for a Dual-Channel FIFO Controller

This block is the SPI slave register port that sits between a host processor and a two-channel serial bus controller. Each channel owns a receive FIFO, filled by the channel engine with a 16-bit word plus a CRC-error bit per entry, and a four-deep transmit FIFO, drained by the channel engine. The host reads received words, a status byte and an interrupt-enable byte, and writes transmit words, all through byte-oriented SPI bursts.

At the start of every burst (chip select going low) the received-data registers of both channels and the status byte are copied into a snapshot. Every byte the host reads during that burst comes from the snapshot, so data and status read together in one burst always agree, even while the channel engines keep pushing new entries. Reading the low data byte of a channel requests a pop of that channel's receive FIFO, which takes effect when chip select returns high. The register pointer advances after each data byte, so a burst that reads the four data bytes leaves the pointer on the status byte, and the command byte of the next burst shifts that status out for free.

An interrupt line reports, per enable bit, the transmit-empty and receive-not-empty conditions of both channels. Inputs on the channel side are plain push and pop strobes standing in for the bus engines.

Top module: `spi_snap_fifo`

## Requirements
- R1: After reset both receive FIFOs and both transmit FIFOs are empty, the interrupt enables are zero, `irq` is 0, `tx_valid` is 0 and the register pointer is 0, so the command byte of the first burst shifts out register 0.
- R2: SPI is mode 0, MSB first: MOSI is sampled on rising SCLK while `spi_cs_n` is low. The first byte of a burst is a command: bit 7 = 1 for write, 0 for read; bits 2:0 = register address; bits 6:3 are ignored. Each following data byte accesses the register at the pointer, after which the pointer increments by one.
- R3: Register addresses: 0 = channel 0 data high byte, 1 = channel 0 data low byte, 2 = channel 1 data high, 3 = channel 1 data low, 4 = status, 5 = interrupt enable (bits 3:0), 6 and 7 read as 0. Status bits: 0 = channel 0 receive not empty, 1 = channel 0 CRC error, 2 = channel 0 transmit empty, 4 = channel 1 receive not empty, 5 = channel 1 CRC error, 6 = channel 1 transmit empty, 3 and 7 = 0. A data register reads 0 while its receive FIFO is empty.
- R4: Status and all four data bytes are captured when `spi_cs_n` falls; FIFO changes during the burst do not alter what the burst reads.
- R5: The command byte of a burst shifts out the register at the pointer left by the previous burst; after a burst that reads from address 0 through address 3, that register is the status byte (address 4) of the new snapshot.
- R6: A read of address 1 (or 3) pops channel 0 (or 1) receive FIFO once, when `spi_cs_n` rises, and only if that channel's snapshot showed it not empty.
- R7: Each receive entry carries its own CRC-error bit; the status error flag of a channel shows the bit of the entry at the head, and reads 0 while that FIFO is empty.
- R8: A write to address 0 (or 2) holds a high byte; a write to address 1 (or 3) pushes {held high byte, written byte} into channel 0 (or 1) transmit FIFO. `tx_valid` and `tx_word0/1` present the FIFO head in write order; a push into a full FIFO (four entries) is dropped.
- R9: `irq` is the OR of enabled conditions: enable bit 0 = channel 0 receive not empty, bit 1 = channel 0 transmit empty, bit 2 = channel 1 receive not empty, bit 3 = channel 1 transmit empty; it follows the live FIFO state, not the snapshot.
- R10: `spi_miso` is 0 while chip select is high.
- R11: Writes to the status address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, SPI pins are oversampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| rx_push | input | 2 | Per-channel receive push strobe |
| rx_word0 | input | 16 | Channel 0 received word |
| rx_word1 | input | 16 | Channel 1 received word |
| rx_crc_err | input | 2 | Per-channel CRC-error bit of the pushed word |
| tx_pop | input | 2 | Per-channel transmit pop strobe |
| tx_word0 | output | 16 | Channel 0 transmit FIFO head |
| tx_word1 | output | 16 | Channel 1 transmit FIFO head |
| tx_valid | output | 2 | Per-channel transmit FIFO not empty |
| irq | output | 1 | Interrupt request |

## Verification
The bench pushes a receive entry in the middle of a burst and confirms the burst still reads an empty channel and unchanged status; a design that read live state would show the new word or a torn status. It alternates CRC-error bits across consecutive entries and reads status from the command byte of the next burst, which catches an error flag stored per FIFO rather than per entry, a flag left set once the FIFO drains, and a pointer that fails to roll onto status. It also reads a low byte of a channel that was empty at snapshot time but filled during the burst, where a careless pop would discard an unseen word, and overfills the transmit FIFO to show the fifth word is dropped rather than overwriting the head.

// File: rtl/spi_snap_pkg.sv
package spi_snap_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int NCH      = 2;
    localparam int IEN_W    = 2 * NCH;

    localparam logic [ADDR_W-1:0] A_D0H = 3'd0;
    localparam logic [ADDR_W-1:0] A_D0L = 3'd1;
    localparam logic [ADDR_W-1:0] A_D1H = 3'd2;
    localparam logic [ADDR_W-1:0] A_D1L = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
    localparam logic [ADDR_W-1:0] A_IEN = 3'd5;

    // status bit positions
    localparam int S_RXNE0 = 0;
    localparam int S_ERR0  = 1;
    localparam int S_TXE0  = 2;
    localparam int S_RXNE1 = 4;
    localparam int S_ERR1  = 5;
    localparam int S_TXE1  = 6;

    typedef struct packed {
        logic [ADDR_W-1:0]          ptr;
        logic                       expect_cmd;
        logic                       wr;
        logic                       load_pend;
        logic [NCH-1:0]             pop_pend;
        logic [BYTE_W-1:0]          snap_stat;
        logic [NCH-1:0][WORD_W-1:0] snap_data;
        logic [NCH-1:0][BYTE_W-1:0] hold_hi;
        logic [IEN_W-1:0]           irq_en;
        logic [BYTE_W-1:0]          out_byte;
    } regs_t;
endpackage

// File: rtl/spi_snap_shifter.sv
module spi_snap_shifter
    import spi_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              miso,
    output logic              cs_fall,
    output logic              cs_rise,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [1:0]        sync_sclk;
        logic [1:0]        sync_cs;
        logic [1:0]        sync_mosi;
        logic              sclk_prev;
        logic              cs_prev;
        logic [CNT_W-1:0]  bit_cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] rx;
        logic              done;
        logic              fall;
        logic              rise;
    } sh_t;

    sh_t st_d, st_q;
    logic sclk_s, cs_s, mosi_s;

    assign sclk_s = st_q.sync_sclk[1];
    assign cs_s   = st_q.sync_cs[1];
    assign mosi_s = st_q.sync_mosi[1];

    always_comb begin
        st_d           = st_q;
        st_d.sync_sclk = {st_q.sync_sclk[0], sclk};
        st_d.sync_cs   = {st_q.sync_cs[0], cs_n};
        st_d.sync_mosi = {st_q.sync_mosi[0], mosi};
        st_d.sclk_prev = sclk_s;
        st_d.cs_prev   = cs_s;
        st_d.fall      = st_q.cs_prev & ~cs_s;
        st_d.rise      = ~st_q.cs_prev & cs_s;
        st_d.done      = 1'b0;
        if (st_q.cs_prev && !cs_s) begin
            st_d.bit_cnt = '0;
        end else if (!cs_s && sclk_s && !st_q.sclk_prev) begin
            st_d.sh      = {st_q.sh[BYTE_W-2:0], mosi_s};
            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            if (st_q.bit_cnt == CNT_W'(BYTE_W - 1)) begin
                st_d.done = 1'b1;
                st_d.rx   = {st_q.sh[BYTE_W-2:0], mosi_s};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.sync_cs   <= 2'b11;
            st_q.cs_prev   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso      = cs_s ? 1'b0 : tx_byte[~st_q.bit_cnt];
    assign cs_fall   = st_q.fall;
    assign cs_rise   = st_q.rise;
    assign byte_done = st_q.done;
    assign rx_byte   = st_q.rx;
endmodule

// File: rtl/spi_snap_sfifo.sv
module spi_snap_sfifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } fp_t;

    fp_t fp_d, fp_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty   = (fp_q.wp == fp_q.rp);
    assign full    = (fp_q.wp[AW] != fp_q.rp[AW]) && (fp_q.wp[AW-1:0] == fp_q.rp[AW-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[fp_q.rp[AW-1:0]];

    always_comb begin
        fp_d = fp_q;
        if (do_push) fp_d.wp = fp_q.wp + 1'b1;
        if (do_pop)  fp_d.rp = fp_q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fp_q <= '0;
        else        fp_q <= fp_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[fp_q.wp[AW-1:0]] <= wdata;
    end
endmodule

// File: rtl/spi_snap_fifo.sv
module spi_snap_fifo
    import spi_snap_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [NCH-1:0]    rx_push,
    input  logic [WORD_W-1:0] rx_word0,
    input  logic [WORD_W-1:0] rx_word1,
    input  logic [NCH-1:0]    rx_crc_err,
    input  logic [NCH-1:0]    tx_pop,
    output logic [WORD_W-1:0] tx_word0,
    output logic [WORD_W-1:0] tx_word1,
    output logic [NCH-1:0]    tx_valid,
    output logic              irq
);
    localparam int RXW = WORD_W + 1;

    regs_t st_d, st_q;

    logic              cs_fall, cs_rise, byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic [NCH-1:0]    rx_empty, rx_full, tx_empty, tx_full;
    logic [NCH-1:0]    rx_pop, tx_push, rx_err_live;
    logic [RXW-1:0]    rx_head [NCH];
    logic [WORD_W-1:0] rx_in [NCH];
    logic [WORD_W-1:0] tx_head [NCH];
    logic [WORD_W-1:0] tx_wdata [NCH];
    logic [WORD_W-1:0] live_data [NCH];
    logic [BYTE_W-1:0] live_stat;
    logic [BYTE_W-1:0] snap_stat;
    logic [IEN_W-1:0]  irq_en;

    assign rx_in[0] = rx_word0;
    assign rx_in[1] = rx_word1;

    spi_snap_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .tx_byte  (st_q.out_byte),
        .miso     (spi_miso),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .byte_done(byte_done),
        .rx_byte  (rx_byte)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        spi_snap_sfifo #(.W(RXW), .DEPTH(RX_DEPTH)) u_rx (
            .clk  (clk),
            .rst_n(rst_n),
            .push (rx_push[c]),
            .wdata({rx_crc_err[c], rx_in[c]}),
            .pop  (rx_pop[c]),
            .head (rx_head[c]),
            .empty(rx_empty[c]),
            .full (rx_full[c])
        );
        spi_snap_sfifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_tx (
            .clk  (clk),
            .rst_n(rst_n),
            .push (tx_push[c]),
            .wdata(tx_wdata[c]),
            .pop  (tx_pop[c]),
            .head (tx_head[c]),
            .empty(tx_empty[c]),
            .full (tx_full[c])
        );
        assign tx_wdata[c]    = {st_q.hold_hi[c], rx_byte};
        assign live_data[c]   = rx_empty[c] ? '0 : rx_head[c][WORD_W-1:0];
        assign rx_err_live[c] = !rx_empty[c] && rx_head[c][WORD_W];
    end

    assign live_stat = {1'b0, tx_empty[1], rx_err_live[1], !rx_empty[1],
                        1'b0, tx_empty[0], rx_err_live[0], !rx_empty[0]};

    function automatic logic [BYTE_W-1:0] rd_reg(input logic [ADDR_W-1:0] a, input regs_t s);
        logic [BYTE_W-1:0] v;
        case (a)
            A_D0H:   v = s.snap_data[0][WORD_W-1:BYTE_W];
            A_D0L:   v = s.snap_data[0][BYTE_W-1:0];
            A_D1H:   v = s.snap_data[1][WORD_W-1:BYTE_W];
            A_D1L:   v = s.snap_data[1][BYTE_W-1:0];
            A_STAT:  v = s.snap_stat;
            A_IEN:   v = BYTE_W'(s.irq_en);
            default: v = '0;
        endcase
        return v;
    endfunction

    always_comb begin
        st_d    = st_q;
        tx_push = '0;
        rx_pop  = '0;

        if (cs_fall) begin
            st_d.snap_stat    = live_stat;
            st_d.snap_data[0] = live_data[0];
            st_d.snap_data[1] = live_data[1];
            st_d.load_pend    = 1'b1;
            st_d.expect_cmd   = 1'b1;
            st_d.pop_pend     = '0;
        end

        if (st_q.load_pend) begin
            st_d.out_byte  = rd_reg(st_q.ptr, st_q);
            st_d.load_pend = 1'b0;
        end

        if (byte_done) begin
            if (st_q.expect_cmd) begin
                st_d.expect_cmd = 1'b0;
                st_d.wr         = rx_byte[BYTE_W-1];
                st_d.ptr        = rx_byte[ADDR_W-1:0];
                st_d.out_byte   = rd_reg(rx_byte[ADDR_W-1:0], st_q);
            end else begin
                if (st_q.wr) begin
                    case (st_q.ptr)
                        A_D0H, A_D1H: st_d.hold_hi[st_q.ptr[1]] = rx_byte;
                        A_D0L, A_D1L: tx_push[st_q.ptr[1]] = 1'b1;
                        A_IEN:        st_d.irq_en = rx_byte[IEN_W-1:0];
                        default:      ;
                    endcase
                end else begin
                    if (st_q.ptr == A_D0L && st_q.snap_stat[S_RXNE0]) st_d.pop_pend[0] = 1'b1;
                    if (st_q.ptr == A_D1L && st_q.snap_stat[S_RXNE1]) st_d.pop_pend[1] = 1'b1;
                end
                st_d.ptr      = st_q.ptr + 1'b1;
                st_d.out_byte = rd_reg(st_q.ptr + 1'b1, st_q);
            end
        end

        if (cs_rise) begin
            rx_pop        = st_q.pop_pend;
            st_d.pop_pend = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap_stat = st_q.snap_stat;
    assign irq_en    = st_q.irq_en;
    assign tx_word0  = tx_head[0];
    assign tx_word1  = tx_head[1];
    assign tx_valid  = ~tx_empty;
    assign irq       = |(irq_en & {tx_empty[1], !rx_empty[1], tx_empty[0], !rx_empty[0]});
endmodule

// File: rtl/spi_snap_fifo_chk.sv
module spi_snap_fifo_chk
    import spi_snap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic              cs_fall,
    input logic              cs_rise,
    input logic              byte_done,
    input logic [NCH-1:0]    rx_pop,
    input logic [NCH-1:0]    rx_empty,
    input logic [NCH-1:0]    tx_push,
    input logic [NCH-1:0]    tx_empty,
    input logic [BYTE_W-1:0] snap_stat,
    input logic [IEN_W-1:0]  irq_en,
    input logic              irq
);
    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) |-> !spi_miso); // R10

    AST_POP_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_pop) |-> cs_rise); // R6

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rx_pop & rx_empty)) |-> 1'b0); // R6

    AST_PUSH_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_push) |-> byte_done); // R8

    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall |=> $stable(snap_stat)); // R4

    AST_IRQ_TXE0: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en[1] && tx_empty[0] |-> irq); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en == '0 |-> !irq); // R9
endmodule

bind spi_snap_fifo spi_snap_fifo_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .byte_done(byte_done),
    .rx_pop   (rx_pop),
    .rx_empty (rx_empty),
    .tx_push  (tx_push),
    .tx_empty (tx_empty),
    .snap_stat(snap_stat),
    .irq_en   (irq_en),
    .irq      (irq)
);

// File: tb/sim_spi_snap_fifo.sv
module sim_spi_snap_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso;
    logic [1:0]  rx_push = '0, rx_crc_err = '0, tx_pop = '0;
    logic [15:0] rx_word0 = '0, rx_word1 = '0;
    logic [15:0] tx_word0, tx_word1;
    logic [1:0]  tx_valid;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] wbuf [8];
    logic [7:0] got [8];
    logic [7:0] cmd_got;

    // {crc_err, word}
    localparam logic [16:0] VEC [4] = '{
        {1'b0, 16'h1234}, {1'b1, 16'hBEEF}, {1'b0, 16'h00FF}, {1'b1, 16'h8001}
    };

    always #5 clk = ~clk;

    spi_snap_fifo u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .rx_push(rx_push), .rx_word0(rx_word0), .rx_word1(rx_word1),
        .rx_crc_err(rx_crc_err), .tx_pop(tx_pop), .tx_word0(tx_word0), .tx_word1(tx_word1),
        .tx_valid(tx_valid), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); mosi = tx[i];
            repeat (8) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk); cs_n = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (8) @(negedge clk); cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic burst(input logic [7:0] cmd, input int n);
        cs_begin();
        xfer(cmd, cmd_got);
        for (int k = 0; k < n; k++) xfer(wbuf[k], got[k]);
        cs_end();
    endtask

    task automatic rx_in(input int c, input logic [15:0] w, input logic e);
        @(negedge clk);
        if (c == 0) rx_word0 = w; else rx_word1 = w;
        rx_crc_err[c] = e; rx_push[c] = 1'b1;
        @(negedge clk); rx_push = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic tx_take(input int c);
        @(negedge clk); tx_pop[c] = 1'b1;
        @(negedge clk); tx_pop = '0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) wbuf[k] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state, R10 idle MISO
        check("R1 tx_valid", tx_valid, 0);
        check("R1 irq", irq, 0);
        check("R10 miso idle", miso, 0);
        burst(8'h04, 1);
        check("R1 cmd byte from reg0", cmd_got, 8'h00);
        check("R1 status after reset", got[0], 8'h44);

        // table walk: R2 R3 R5 R6 R7
        for (int i = 0; i < 4; i++) rx_in(0, VEC[i][15:0], VEC[i][16]);
        for (int i = 0; i < 4; i++) begin
            burst(8'h00, 4);
            if (i > 0)
                check("R5 R7 status on command byte", cmd_got, 8'h45 | (int'(VEC[i][16]) << 1));
            check("R2 R3 ch0 high", got[0], VEC[i][15:8]);
            check("R2 R3 ch0 low", got[1], VEC[i][7:0]);
            check("R3 ch1 empty reads 0", {got[2], got[3]}, 0);
        end
        burst(8'h00, 4);
        check("R7 error clear when empty", cmd_got, 8'h44);
        check("R6 all popped", {got[0], got[1]}, 0);

        // R4 snapshot held during burst; R6 no pop of unseen entry
        cs_begin();
        xfer(8'h02, cmd_got);
        rx_in(1, 16'hC0DE, 1'b1);
        xfer(8'h00, got[0]);
        xfer(8'h00, got[1]);
        xfer(8'h00, got[2]);
        cs_end();
        check("R4 ch1 data frozen", {got[0], got[1]}, 0);
        check("R4 status frozen", got[2], 8'h44);
        burst(8'h02, 3);
        check("R6 unseen entry kept", {got[0], got[1]}, 16'hC0DE);
        check("R7 ch1 error flag", got[2], 8'h74);
        burst(8'h04, 1);
        check("R6 pop at rise", got[0], 8'h44);

        // R8 writes, pointer increments across both channels
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        burst(8'h80, 4);
        check("R8 tx_valid both", tx_valid, 2'b11);
        check("R8 ch0 word", tx_word0, 16'h1122);
        check("R8 ch1 word", tx_word1, 16'h3344);
        for (int k = 1; k <= 4; k++) begin
            wbuf[0] = 8'hA0; wbuf[1] = 8'(k);
            burst(8'h80, 2);
        end
        burst(8'h04, 1);
        check("R3 status tx not empty", got[0], 8'h00);
        check("R8 head order 0", tx_word0, 16'h1122);
        for (int k = 1; k <= 3; k++) begin
            tx_take(0);
            check("R8 head order", tx_word0, 16'hA000 + k);
        end
        tx_take(0);
        check("R8 full push dropped", tx_valid[0], 0);

        // R11 status write ignored
        wbuf[0] = 8'hFF;
        burst(8'h84, 1);
        burst(8'h04, 1);
        check("R11 status unchanged", got[0], 8'h04);

        // R9 interrupt enables
        wbuf[0] = 8'h02;
        burst(8'h85, 1);
        check("R9 irq txe0", irq, 1);
        burst(8'h05, 1);
        check("R3 enable readback", got[0], 8'h02);
        wbuf[0] = 8'h55; wbuf[1] = 8'h66;
        burst(8'h80, 2);
        check("R9 irq drops when tx filled", irq, 0);
        wbuf[0] = 8'h04;
        burst(8'h85, 1);
        check("R9 irq rxne1 empty", irq, 0);
        rx_in(1, 16'h0F0F, 1'b0);
        check("R9 irq rxne1", irq, 1);
        check("R10 miso idle at end", miso, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule